// File: doc/BRIEF.md
# Key-Locked Debug and Boot Gate

This block holds a part's debug access and its choice of external boot source closed while code protection is on. An outside test access port controller feeds it serial data and its shift and update strobes. A dedicated key register, selected by the controller, collects a 64-bit word one bit at a time. On the update strobe, that word is checked against a stored secret key, which another block supplies.

The gate opens only when every bit matches and a full key length has been shifted since the last update. It then stays open until the next system reset. A key that does not match is dropped without any visible effect. While the gate is closed, emulation is disabled and the boot source output is forced to the internal memory code, whatever the boot configuration pins say. Once the gate is open, or whenever protection is turned off, the pin value passes straight through.

Top module: `dbg_key_gate`

## Requirements
- R1: A synchronous active-low reset closes the gate when protection is on, clears the key register to zero and clears the shifted-bit count.
- R2: Each cycle with both `shift_dr` and `key_sel` high shifts `tdi` into the top bit of the key register and moves every bit one place toward bit 0. The key is therefore entered LSB first. `tdo` always shows bit 0 of the register.
- R3: A `shift_dr` pulse while `key_sel` is low changes neither the key register nor the shifted-bit count.
- R4: An `update_dr` pulse while `key_sel` is high opens the gate from the next cycle on. This happens only when all 64 register bits equal `stored_key` and at least 64 bits have been shifted since reset or since the last selected update.
- R5: A selected update with a key that differs in any bit leaves the gate closed, with no change to `unlocked`, `emu_en` or `boot_src`.
- R6: A selected update clears the shifted-bit count. Fewer than 64 shifts after reset or after the previous update never open the gate, even when the register already equals the stored key.
- R7: An `update_dr` pulse while `key_sel` is low never opens the gate.
- R8: Once open, the gate stays open until reset, even after later wrong keys or a change of `stored_key`.
- R9: While `sec_en` is low, `unlocked` is high in every cycle.
- R10: While the gate is closed, `boot_src` is 2'b11 (internal memory), whatever `boot_cfg` is. While it is open, `boot_src` equals `boot_cfg`.
- R11: `emu_en` equals `unlocked` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| sec_en | input | 1 | Code protection enabled |
| key_sel | input | 1 | Key register selected by the test controller |
| shift_dr | input | 1 | Shift strobe from the test controller |
| update_dr | input | 1 | Update strobe from the test controller |
| tdi | input | 1 | Serial key data in |
| tdo | output | 1 | Bit 0 of the key register |
| stored_key | input | 64 | Secret key to compare against |
| boot_cfg | input | 2 | Boot configuration pin value |
| boot_src | output | 2 | Boot source after gating |
| emu_en | output | 1 | Emulation access enabled |
| unlocked | output | 1 | Gate open |

## Verification
On every cycle, the assertions check the output gating: a forced internal boot code while closed, a pass-through of the pins while open, `emu_en` tracking `unlocked`, and an open gate whenever protection is off. They also check that the gate never opens without a selected update, never closes again without reset, and that an unselected shift leaves `tdo` unchanged. Only the bench scenarios can show that the comparison uses the whole key in LSB-first order. The same holds for three other cases: a single wrong bit at either end is rejected, a partial shift of a matching pattern is refused, and a wrong update after unlocking leaves the gate open.

// File: rtl/dbg_key_gate_pkg.sv
// Package: shared constants and types for the key-locked debug gate.
// Assumes a two-bit boot source code, with 2'b11 meaning internal memory.
package dbg_key_gate_pkg;
    localparam int BOOT_W = 2;
    localparam logic [BOOT_W-1:0] BOOT_INTERNAL = 2'b11;

    typedef enum logic {
        GATE_LOCKED   = 1'b0,
        GATE_UNLOCKED = 1'b1
    } gate_state_t;
endpackage

// File: rtl/dkg_key_sreg.sv
// Key shift register with a shifted-bit counter.
// It shifts serial data in LSB first toward bit 0 on a selected shift strobe.
// It counts shifts up to KEY_W and saturates there. A selected update clears
// the count. The strobes are assumed to come from a controller that never
// raises shift and update together.
module dkg_key_sreg #(
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_sel,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    output logic [KEY_W-1:0] key_q,
    output logic             full,
    output logic             tdo
);
    localparam int CNT_W = $clog2(KEY_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(KEY_W);

    logic [CNT_W-1:0] cnt_q;
    logic             do_shift;
    logic             do_update;

    assign do_shift  = key_sel && shift_dr;
    assign do_update = key_sel && update_dr;

    // Shift new serial data in at the top bit, moving old bits toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (do_shift) begin
            key_q <= {tdi, key_q[KEY_W-1:1]};
        end
    end

    // Count shifts since the last selected update, saturating at the key length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (do_update) begin
            cnt_q <= '0;
        end else if (do_shift && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CNT_MAX);
    assign tdo  = key_q[0];
endmodule

// File: rtl/dkg_key_cmp.sv
// Full-width key comparator.
// It splits the key into SEG_W-bit segments, compares each one in parallel
// and ANDs the results, so all bits are judged in one cycle.
// Assumes KEY_W is a multiple of SEG_W.
module dkg_key_cmp #(
    parameter int KEY_W = 64,
    parameter int SEG_W = 8
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    output logic             match
);
    localparam int N_SEG = KEY_W / SEG_W;

    logic [N_SEG-1:0] seg_eq;

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        // Equality of one segment.
        assign seg_eq[g] = (key_a[g*SEG_W +: SEG_W] == key_b[g*SEG_W +: SEG_W]);
    end

    assign match = &seg_eq;
endmodule

// File: rtl/dkg_lock_fsm.sv
// Lock state machine.
// It leaves the locked state only on a selected update that arrives with a
// full-length match. After that it stays unlocked until reset.
module dkg_lock_fsm
    import dbg_key_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_sel,
    input  logic update_dr,
    input  logic match,
    input  logic full,
    output logic open_q
);
    gate_state_t state_q;
    gate_state_t state_d;

    // Next-state choice: one way only, from locked to unlocked.
    always_comb begin
        state_d = state_q;
        if (state_q == GATE_LOCKED && key_sel && update_dr && match && full) begin
            state_d = GATE_UNLOCKED;
        end
    end

    // State register, cleared to locked by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    assign open_q = (state_q == GATE_UNLOCKED);
endmodule

// File: rtl/dbg_key_gate.sv
// Top of the key-locked debug and boot gate.
// It joins the key register, the comparator and the lock FSM, and gates the
// emulation enable and the boot source. Assumes stored_key is stable while
// an update is in progress.
module dbg_key_gate
    import dbg_key_gate_pkg::*;
#(
    parameter int KEY_W = 64,
    parameter int SEG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_en,
    input  logic              key_sel,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [KEY_W-1:0]  stored_key,
    input  logic [BOOT_W-1:0] boot_cfg,
    output logic [BOOT_W-1:0] boot_src,
    output logic              emu_en,
    output logic              unlocked
);
    logic [KEY_W-1:0] key_q;
    logic             full;
    logic             match;
    logic             open_q;

    dkg_key_sreg #(.KEY_W(KEY_W)) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_sel   (key_sel),
        .shift_dr  (shift_dr),
        .update_dr (update_dr),
        .tdi       (tdi),
        .key_q     (key_q),
        .full      (full),
        .tdo       (tdo)
    );

    dkg_key_cmp #(.KEY_W(KEY_W), .SEG_W(SEG_W)) u_cmp (
        .key_a (key_q),
        .key_b (stored_key),
        .match (match)
    );

    dkg_lock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_sel   (key_sel),
        .update_dr (update_dr),
        .match     (match),
        .full      (full),
        .open_q    (open_q)
    );

    // Output gating: open when unlocked or when protection is off.
    always_comb begin
        unlocked = open_q || !sec_en;
        emu_en   = unlocked;
        boot_src = unlocked ? boot_cfg : BOOT_INTERNAL;
    end
endmodule

// File: rtl/dbg_key_gate_chk.sv
// Checker for the key-locked gate, attached to every instance of the top by bind.
module dbg_key_gate_chk
    import dbg_key_gate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sec_en,
    input logic              key_sel,
    input logic              shift_dr,
    input logic              update_dr,
    input logic              tdo,
    input logic [BOOT_W-1:0] boot_cfg,
    input logic [BOOT_W-1:0] boot_src,
    input logic              emu_en,
    input logic              unlocked
);
    AST_LOCKED_BOOT_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> boot_src == BOOT_INTERNAL);                                    // R10
    AST_OPEN_BOOT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> boot_src == boot_cfg);                                          // R10
    AST_EMU_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        emu_en == unlocked);                                                         // R11
    AST_NO_SEC_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_en |-> unlocked);                                                       // R9
    AST_STICKY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && sec_en) |=> unlocked);                                          // R8
    AST_NO_OPEN_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_en && !unlocked && !(update_dr && key_sel) && $past(sec_en)) |=> (!unlocked || !sec_en)); // R4
    AST_UNSEL_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_dr && key_sel) |=> $stable(tdo));                                    // R3
endmodule

bind dbg_key_gate dbg_key_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_en    (sec_en),
    .key_sel   (key_sel),
    .shift_dr  (shift_dr),
    .update_dr (update_dr),
    .tdo       (tdo),
    .boot_cfg  (boot_cfg),
    .boot_src  (boot_src),
    .emu_en    (emu_en),
    .unlocked  (unlocked)
);

// File: tb/test_dbg_key_gate.sv
module test_dbg_key_gate;
    localparam time CLK_PERIOD = 10ns;
    localparam int  KW = 64;

    typedef struct packed {
        logic [KW-1:0] key;
        logic [KW-1:0] stored;
        logic [7:0]    nbits;
        logic          exp_open;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 8'd64, 1'b1}, // R4 match
        '{64'h8123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 8'd64, 1'b0}, // R5 bit 63 wrong
        '{64'h0123_4567_89AB_CDEE, 64'h0123_4567_89AB_CDEF, 8'd64, 1'b0}, // R5 bit 0 wrong
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 8'd64, 1'b1}, // R4 zero key
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 8'd63, 1'b0}, // R6 partial
        '{64'hFFFF_0000_A5A5_5A5A, 64'hFFFF_0000_A5A5_5A5A, 8'd64, 1'b1}  // R4 mixed
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_en = 1'b1;
    logic          key_sel = 1'b0;
    logic          shift_dr = 1'b0;
    logic          update_dr = 1'b0;
    logic          tdi = 1'b0;
    logic          tdo;
    logic [KW-1:0] stored_key = '0;
    logic [1:0]    boot_cfg = 2'b01;
    logic [1:0]    boot_src;
    logic          emu_en;
    logic          unlocked;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_key_gate i_dbg_key_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_en     (sec_en),
        .key_sel    (key_sel),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .stored_key (stored_key),
        .boot_cfg   (boot_cfg),
        .boot_src   (boot_src),
        .emu_en     (emu_en),
        .unlocked   (unlocked)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; key_sel = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic shift_bits(input logic [KW-1:0] val, input int n, input logic sel);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tdi = val[i]; shift_dr = 1'b1; key_sel = sel;
        end
        @(negedge clk);
        shift_dr = 1'b0; key_sel = 1'b0;
    endtask

    task automatic update(input logic sel);
        @(negedge clk);
        update_dr = 1'b1; key_sel = sel;
        @(negedge clk);
        update_dr = 1'b0; key_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 locked after reset", 64'(unlocked), 64'd0);
        check("R1 key register cleared", 64'(tdo), 64'd0);
        check("R10 internal boot while locked", 64'(boot_src), 64'h3);
        check("R11 emu off while locked", 64'(emu_en), 64'd0);

        // Vector table: reset, shift, update, compare the gate state.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            stored_key = VECS[v].stored;
            shift_bits(VECS[v].key, int'(VECS[v].nbits), 1'b1);
            update(1'b1);
            check($sformatf("R4/R5/R6 vector %0d unlocked", v), 64'(unlocked), 64'(VECS[v].exp_open));
            check($sformatf("R11 vector %0d emu", v), 64'(emu_en), 64'(VECS[v].exp_open));
        end

        // R2: LSB-first order, seen on tdo.
        do_reset();
        shift_bits(64'h0000_0000_0000_0002, 64, 1'b1);
        check("R2 tdo shows bit 0", 64'(tdo), 64'd0);
        shift_bits(64'h0, 1, 1'b1);
        check("R2 next bit reaches tdo", 64'(tdo), 64'd1);

        // R3: an unselected shift leaves the register and the count alone.
        do_reset();
        stored_key = 64'h1;
        shift_bits(64'h1, 64, 1'b1);
        shift_bits(64'h0, 5, 1'b0);
        check("R3 unselected shift keeps tdo", 64'(tdo), 64'd1);
        update(1'b1);
        check("R3 key intact and unlocks", 64'(unlocked), 64'd1);

        // R7: an unselected update never opens the gate.
        do_reset();
        stored_key = 64'hDEAD_BEEF_0000_1111;
        shift_bits(64'hDEAD_BEEF_0000_1111, 64, 1'b1);
        update(1'b0);
        check("R7 unselected update ignored", 64'(unlocked), 64'd0);

        // R6: a selected update clears the count, so a repeat update without shifting fails.
        do_reset();
        stored_key = 64'h5555_AAAA_5555_AAAA;
        shift_bits(64'h5555_AAAA_5555_AAAA, 64, 1'b1);
        stored_key = 64'h0;
        update(1'b1);
        check("R5 wrong key stays locked", 64'(unlocked), 64'd0);
        check("R5 boot stays internal", 64'(boot_src), 64'h3);
        stored_key = 64'h5555_AAAA_5555_AAAA;
        update(1'b1);
        check("R6 update without new shifts stays locked", 64'(unlocked), 64'd0);

        // R8: sticky after unlock; R10: pins pass through.
        shift_bits(64'h5555_AAAA_5555_AAAA, 64, 1'b1);
        update(1'b1);
        check("R4 unlock after full reshift", 64'(unlocked), 64'd1);
        boot_cfg = 2'b10;
        @(negedge clk);
        check("R10 boot passes when open", 64'(boot_src), 64'h2);
        stored_key = 64'h0;
        shift_bits(64'h1234, 64, 1'b1);
        update(1'b1);
        check("R8 stays open after wrong key", 64'(unlocked), 64'd1);
        do_reset();
        @(negedge clk);
        check("R8 reset relocks", 64'(unlocked), 64'd0);
        check("R10 locked ignores pins", 64'(boot_src), 64'h3);

        // R9: protection off.
        sec_en = 1'b0;
        boot_cfg = 2'b00;
        @(negedge clk);
        check("R9 open with security off", 64'(unlocked), 64'd1);
        check("R9 emu on with security off", 64'(emu_en), 64'd1);
        check("R9 boot passes with security off", 64'(boot_src), 64'h0);
        sec_en = 1'b1;
        @(negedge clk);
        check("R9 relocks when security on", 64'(unlocked), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule